// File: doc/BRIEF.md
# Reset Source Controller with Cause Flags

This block decides when the processor core must be held in reset and records why. It watches two sources: a reset pin driven from outside the chip, and a brown-out detect line from an analog supply monitor. The pin is synchronised and must stay high for a minimum run of clock cycles before it counts. Once a source is accepted, the block asserts its core reset output and holds it for a fixed stretch after the source goes away.

Each accepted source leaves a sticky flag in a status register, and that register is readable over a small register bus. The flags survive the resets they record, so boot code can read the cause and then clear the flags by writing zeros. Brown-out detection always raises its own flag. It resets the core only when the enable bit in an auxiliary control register is set. Two further flag bits, for software-requested and illegal-address resets, are set from event inputs. Only the power-on reset input returns every flag and control bit to zero.

Top module: `rst_cause_ctrl`

## Requirements
- R1: While `por_n` is low, and right after it rises, `core_rst` is 0, the status register (address 0x97) reads 0x00 and the auxiliary register (address 0xA6) reads 0x00.
- R2: A pin reset is accepted when `ext_pin` is high for at least 24 consecutive clock edges. With 2 synchroniser stages, `core_rst` is first seen high after the 27th edge counted from the first high sample.
- R3: A high pulse on `ext_pin` of 23 edges or fewer, or a run broken by any low sample, is ignored. `core_rst` stays 0 and status bit 6 stays 0.
- R4: `core_rst` stays high while the qualified pin is high and for 16 more cycles after that. Status bit 6 (external-reset flag) becomes 1 on the same edge where `core_rst` falls, and not before.
- R5: Two edges after `bod_in` is synchronised high, status bit 0 (brown-out detect flag) is 1, even when brown-out reset is disabled. With the enable at 0, `core_rst` stays 0.
- R6: When auxiliary bit 6 (brown-out reset enable) is 1, an active `bod_in` drives `core_rst` high while the input is active and for 16 cycles after it. Status bit 5 (brown-out reset flag) is set on the edge where `core_rst` falls.
- R7: Writing to the status register clears each flag whose write-data bit is 0, and writing 1 leaves the flag unchanged. A hardware set in the same cycle as a clearing write wins.
- R8: Status bits 3..1 always read 0. Auxiliary bits other than bit 6 read 0. Unmapped addresses read 0x00.
- R9: A one-cycle pulse on `sw_rst_evt` sets status bit 7, and a one-cycle pulse on `ill_addr_evt` sets status bit 4, each one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_pin | input | 1 | External reset pin, active high, asynchronous |
| bod_in | input | 1 | Brown-out detect from the supply monitor, active high |
| sw_rst_evt | input | 1 | Pulse that records a software-requested reset |
| ill_addr_evt | input | 1 | Pulse that records an illegal-address reset |
| sfr_addr | input | 8 | Register bus address |
| sfr_we | input | 1 | Register bus write strobe |
| sfr_wdata | input | 8 | Register bus write data |
| sfr_rdata | output | 8 | Register bus read data, combinational from the address |
| core_rst | output | 1 | Reset to the processor core, active high |

## Verification
Every result has a fixed latency, and the bench samples it on the falling edge of exactly that cycle. `core_rst` first appears high 27 edges after a pin rise. It falls, and the cause flag appears, 19 edges after the pin is released. A brown-out flag appears 3 edges after `bod_in` rises, and an enabled brown-out reset asserts `core_rst` on that same edge. The bench probes one edge before and one edge after each deadline. It also compares `core_rst` on every clock against a behavioural model that counts run lengths and stretch time in plain integers. High-time totals are counted as well, because those counts separate an off-by-one threshold from a correct one.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int REG_W  = 8;
  localparam int SWR_B  = 7;
  localparam int EXR_B  = 6;
  localparam int BOR_B  = 5;
  localparam int IAR_B  = 4;
  localparam int BOD_B  = 0;
  localparam int ENA_B  = 6;
  localparam logic [REG_W-1:0] FLAG_MASK = 8'hF1;
  localparam logic [REG_W-1:0] AUX_MASK  = 8'h40;

  // flags after one edge: a write may only clear, hardware may only set
  function automatic logic [REG_W-1:0] flags_next(
    input logic [REG_W-1:0] cur,
    input logic             wr_hit,
    input logic [REG_W-1:0] wdata,
    input logic [REG_W-1:0] set_vec);
    logic [REG_W-1:0] kept;
    kept = wr_hit ? (cur & wdata) : cur;
    return (kept | set_vec) & FLAG_MASK;
  endfunction
endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/rsc_pin_qual.sv
module rsc_pin_qual #(
  parameter int HOLD_CYC = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  output logic pin_ok
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(HOLD_CYC);

  logic [CW-1:0] run_q;

  // any low sample restarts the run; the count saturates at the limit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             run_q <= '0;
    else if (!pin_s)        run_q <= '0;
    else if (run_q != LIM)  run_q <= run_q + 1'b1;
  end

  assign pin_ok = (run_q == LIM);
endmodule

// File: rtl/rsc_stretch.sv
module rsc_stretch #(
  parameter int STRETCH = 16,
  parameter int NSRC    = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] trig,
  output logic            rst_active,
  output logic            done,
  output logic [NSRC-1:0] done_src
);
  localparam int CW = $clog2(STRETCH + 1);
  localparam logic [CW-1:0] LOAD = CW'(STRETCH);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0]   cnt_q;
  logic [NSRC-1:0] src_q;
  logic            trig_any;

  assign trig_any = |trig;
  assign done     = (cnt_q == ONE) && !trig_any;
  assign done_src = done ? src_q : '0;
  assign rst_active = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      src_q <= '0;
    end else if (trig_any) begin
      cnt_q <= LOAD;
      src_q <= src_q | trig;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (done) src_q <= '0;
    end
  end
endmodule

// File: rtl/rsc_regs.sv
module rsc_regs
  import rsc_pkg::*;
#(
  parameter int               ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h97,
  parameter logic [ADDR_W-1:0] AUX_ADDR  = 8'hA6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [REG_W-1:0]  wdata,
  input  logic [REG_W-1:0]  set_vec,
  output logic [REG_W-1:0]  stat_q,
  output logic              bore_en,
  output logic [REG_W-1:0]  rdata
);
  logic stat_hit, aux_hit;
  assign stat_hit = we && (addr == STAT_ADDR);
  assign aux_hit  = we && (addr == AUX_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      bore_en <= 1'b0;
    end else begin
      stat_q <= flags_next(stat_q, stat_hit, wdata, set_vec);
      if (aux_hit) bore_en <= wdata[ENA_B];
    end
  end

  always_comb begin
    if (addr == STAT_ADDR)     rdata = stat_q & FLAG_MASK;
    else if (addr == AUX_ADDR) rdata = {{(REG_W-1-ENA_B){1'b0}}, bore_en, {ENA_B{1'b0}}} & AUX_MASK;
    else                       rdata = '0;
  end
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rsc_pkg::*;
#(
  parameter int               HOLD_CYC    = 24,
  parameter int               STRETCH     = 16,
  parameter int               SYNC_STAGES = 2,
  parameter int               ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR   = 8'h97,
  parameter logic [ADDR_W-1:0] AUX_ADDR    = 8'hA6
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              ext_pin,
  input  logic              bod_in,
  input  logic              sw_rst_evt,
  input  logic              ill_addr_evt,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic              sfr_we,
  input  logic [REG_W-1:0]  sfr_wdata,
  output logic [REG_W-1:0]  sfr_rdata,
  output logic              core_rst
);
  localparam int NIN = 2;

  // named internal events, visible to the bound checker
  logic [NIN-1:0]   raw_in, syn_in;
  logic             pin_s, bod_s, pin_ok, bod_trig;
  logic             str_done, done_ext, done_bod;
  logic [NIN-1:0]   done_src;
  logic [REG_W-1:0] set_vec, stat_q;
  logic             bore_en;

  assign raw_in = {bod_in, ext_pin};

  for (genvar i = 0; i < NIN; i++) begin : g_sync
    rsc_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(por_n), .d(raw_in[i]), .q(syn_in[i]));
  end

  assign pin_s = syn_in[0];
  assign bod_s = syn_in[1];

  rsc_pin_qual #(.HOLD_CYC(HOLD_CYC)) qual_i (
    .clk(clk), .rst_n(por_n), .pin_s(pin_s), .pin_ok(pin_ok));

  assign bod_trig = bod_s && bore_en;

  rsc_stretch #(.STRETCH(STRETCH), .NSRC(NIN)) str_i (
    .clk(clk), .rst_n(por_n), .trig({bod_trig, pin_ok}),
    .rst_active(core_rst), .done(str_done), .done_src(done_src));

  assign done_ext = done_src[0];
  assign done_bod = done_src[1];

  always_comb begin
    set_vec        = '0;
    set_vec[SWR_B] = sw_rst_evt;
    set_vec[EXR_B] = done_ext;
    set_vec[BOR_B] = done_bod;
    set_vec[IAR_B] = ill_addr_evt;
    set_vec[BOD_B] = bod_s;
  end

  rsc_regs #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .AUX_ADDR(AUX_ADDR)) regs_i (
    .clk(clk), .rst_n(por_n), .addr(sfr_addr), .we(sfr_we), .wdata(sfr_wdata),
    .set_vec(set_vec), .stat_q(stat_q), .bore_en(bore_en), .rdata(sfr_rdata));
endmodule

// File: rtl/rsc_chk.sv
module rsc_chk #(
  parameter int               ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h97
) (
  input logic              clk,
  input logic              por_n,
  input logic              pin_ok,
  input logic              bod_s,
  input logic              bore_en,
  input logic              done_ext,
  input logic              done_bod,
  input logic              str_done,
  input logic [7:0]        set_vec,
  input logic [7:0]        stat_q,
  input logic [ADDR_W-1:0] sfr_addr,
  input logic [7:0]        sfr_rdata,
  input logic              core_rst
);
  // R2
  pin_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
    pin_ok |=> core_rst);

  // R5
  bod_flag_chk: assert property (@(posedge clk) disable iff (!por_n)
    bod_s |=> stat_q[0]);

  // R3
  rst_cause_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(core_rst) |-> $past(pin_ok || (bod_s && bore_en)));

  // R4
  exr_flag_chk: assert property (@(posedge clk) disable iff (!por_n)
    (str_done && done_ext) |=> (stat_q[6] && !core_rst));

  // R6
  bor_flag_chk: assert property (@(posedge clk) disable iff (!por_n)
    done_bod |=> stat_q[5]);

  // R7
  no_sw_set_chk: assert property (@(posedge clk) disable iff (!por_n)
    (set_vec == 8'h00) |=> ((stat_q & ~$past(stat_q)) == 8'h00));

  // R8
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
    (sfr_addr == STAT_ADDR) |-> (sfr_rdata[3:1] == 3'b000));
endmodule

bind rst_cause_ctrl rsc_chk #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) chk_i (
  .clk(clk), .por_n(por_n), .pin_ok(pin_ok), .bod_s(bod_s), .bore_en(bore_en),
  .done_ext(done_ext), .done_bod(done_bod), .str_done(str_done), .set_vec(set_vec),
  .stat_q(stat_q), .sfr_addr(sfr_addr), .sfr_rdata(sfr_rdata), .core_rst(core_rst));

// File: tb/rst_cause_ctrl_tb.sv
module rst_cause_ctrl_tb_top;
  localparam logic [7:0] STAT = 8'h97;
  localparam logic [7:0] AUX  = 8'hA6;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       ext_pin = 1'b0, bod_in = 1'b0, sw_rst_evt = 1'b0, ill_addr_evt = 1'b0;
  logic [7:0] sfr_addr = 8'h00, sfr_wdata = 8'h00;
  logic       sfr_we = 1'b0;
  logic [7:0] sfr_rdata;
  logic       core_rst;

  int errors = 0;
  int checks = 0;
  int hi_cnt = 0;

  always #5 clk = ~clk;

  rst_cause_ctrl dut_i (
    .clk(clk), .por_n(por_n), .ext_pin(ext_pin), .bod_in(bod_in),
    .sw_rst_evt(sw_rst_evt), .ill_addr_evt(ill_addr_evt),
    .sfr_addr(sfr_addr), .sfr_we(sfr_we), .sfr_wdata(sfr_wdata),
    .sfr_rdata(sfr_rdata), .core_rst(core_rst));

  // behavioural reference for core_rst: plain integer run and stretch timers
  int p1, p2, b1, b2, run, stretch, m_en;
  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      p1 = 0; p2 = 0; b1 = 0; b2 = 0; run = 0; stretch = 0; m_en = 0;
    end else begin
      if ((run >= 24) || (b2 == 1 && m_en == 1)) stretch = 16;
      else if (stretch > 0) stretch = stretch - 1;
      run = (p2 == 1) ? ((run < 24) ? run + 1 : 24) : 0;
      p2 = p1; p1 = int'(ext_pin);
      b2 = b1; b1 = int'(bod_in);
      if (sfr_we && sfr_addr == AUX) m_en = int'(sfr_wdata[6]);
    end
  end

  always @(negedge clk) begin
    if (por_n) begin
      if (core_rst) hi_cnt++;
      checks++;
      if (core_rst !== (stretch > 0)) begin
        errors++;
        $display("FAIL R4 model compare core_rst: actual=%0b expected=%0b", core_rst, stretch > 0);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
    step(1);
    sfr_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input int exp);
    sfr_addr = a;
    #1;
    chk(req, int'(sfr_rdata), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3);
    // R1 during reset
    chk("R1 core_rst in reset", int'(core_rst), 0);
    rd("R1 status in reset", STAT, 8'h00);
    por_n = 1'b1;
    step(2);
    chk("R1 core_rst after reset", int'(core_rst), 0);
    rd("R1 status after reset", STAT, 8'h00);
    rd("R1 aux after reset", AUX, 8'h00);

    // R3 short pulse of 23 edges
    hi_cnt = 0;
    ext_pin = 1'b1; step(23); ext_pin = 1'b0; step(40);
    chk("R3 23-cycle pulse core_rst count", hi_cnt, 0);
    rd("R3 23-cycle pulse status", STAT, 8'h00);
    // R3 broken run
    ext_pin = 1'b1; step(20); ext_pin = 1'b0; step(1);
    ext_pin = 1'b1; step(20); ext_pin = 1'b0; step(40);
    chk("R3 broken run core_rst count", hi_cnt, 0);
    rd("R3 broken run status", STAT, 8'h00);

    // R2 / R4 30-edge pin reset with exact timing
    hi_cnt = 0;
    ext_pin = 1'b1;
    step(26); chk("R2 core_rst before edge 27", int'(core_rst), 0);
    step(1);  chk("R2 core_rst at edge 27", int'(core_rst), 1);
    step(3);  ext_pin = 1'b0;
    step(18); chk("R4 core_rst still stretched", int'(core_rst), 1);
    rd("R4 flag not yet set", STAT, 8'h00);
    step(1);  chk("R4 core_rst released", int'(core_rst), 0);
    rd("R4 external flag at release", STAT, 8'h40);
    step(5);
    chk("R4 high time for 30-edge pin", hi_cnt, 22);

    // R7 write ones then clear
    wr(STAT, 8'hFF);
    rd("R7 write ones no effect", STAT, 8'h40);
    wr(STAT, 8'hBF);
    rd("R7 write zero clears", STAT, 8'h00);

    // R2 exactly 24 edges accepted
    hi_cnt = 0;
    ext_pin = 1'b1; step(24); ext_pin = 1'b0; step(40);
    chk("R2 24-edge pin high time", hi_cnt, 16);
    rd("R2 24-edge pin flag", STAT, 8'h40);
    wr(STAT, 8'h00);

    // R5 brown-out with enable 0
    hi_cnt = 0;
    bod_in = 1'b1;
    step(2); rd("R5 bod flag before third edge", STAT, 8'h00);
    step(1); rd("R5 bod flag at third edge", STAT, 8'h01);
    step(2); bod_in = 1'b0; step(30);
    chk("R5 no core reset when disabled", hi_cnt, 0);
    rd("R5 bod flag sticky", STAT, 8'h01);
    wr(STAT, 8'h00);

    // R8 aux only bit 6
    wr(AUX, 8'hFF);
    rd("R8 aux mask", AUX, 8'h40);

    // R6 enabled brown-out reset
    hi_cnt = 0;
    bod_in = 1'b1; step(5); bod_in = 1'b0; step(40);
    chk("R6 brown-out reset high time", hi_cnt, 20);
    rd("R6 brown-out reset flags", STAT, 8'h21);
    wr(STAT, 8'h00);

    // R8 reserved and unmapped
    wr(STAT, 8'h0E);
    rd("R8 reserved bits", STAT, 8'h00);
    rd("R8 unmapped address", 8'h55, 8'h00);

    // R9 event inputs
    sw_rst_evt = 1'b1; step(1); sw_rst_evt = 1'b0;
    rd("R9 software flag", STAT, 8'h80);
    ill_addr_evt = 1'b1; step(1); ill_addr_evt = 1'b0;
    rd("R9 illegal-address flag", STAT, 8'h90);

    // R7 set wins over same-cycle clear
    sfr_addr = STAT; sfr_wdata = 8'h00; sfr_we = 1'b1; sw_rst_evt = 1'b1;
    step(1);
    sfr_we = 1'b0; sw_rst_evt = 1'b0;
    rd("R7 set beats clear", STAT, 8'h80);

    // R1 power-on reset clears everything
    por_n = 1'b0; step(2);
    rd("R1 status cleared by power-on", STAT, 8'h00);
    rd("R1 aux cleared by power-on", AUX, 8'h00);
    por_n = 1'b1; step(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule